// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver with Status Flags

The block moves 8-bit frames in both directions at once over a three-wire link. It drives a serial clock that it generates itself, shifts a byte out on the transmit line and, on the same clock edges, shifts a byte in from the receive line. The bit order is least significant bit first. A simple register interface lets a host load the byte to send, fetch the byte received, set the enables and service three status flags: transmit-empty, receive-full and overrun. Each flag, when its interrupt enable is set, drives one of three interrupt request lines.

A flag is cleared by reading the status register and then writing 0 to that bit. A DMA engine can service the block through two strobes: one writes the transmit byte and one reads the received byte. Each strobe also clears its flag. If a frame completes while the last received byte has not been collected, the overrun flag is set. The new byte is then discarded, and no further frame is started until the host clears overrun. A host that refills the transmit register in time keeps the clock running with no gap between frames.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, the status register reads 0x01 (transmit-empty set, receive-full and overrun clear) and the control register reads 0x00. The serial clock and the transmit line are high, and all three interrupt lines are low.
- R2: Register offsets are 0 for transmit data, 1 for receive data, 2 for status and 3 for control. Status bits are bit 0 transmit-empty, bit 1 receive-full and bit 2 overrun. Control bits are bit 0 transmit enable, bit 1 receive enable, bit 2 transmit interrupt enable and bit 3 receive interrupt enable.
- R3: A frame starts only when transmit is enabled, transmit-empty is 0 and overrun is 0. Starting a frame copies the transmit register into the shifter and sets transmit-empty back to 1.
- R4: A status flag is cleared only by writing 0 to its bit after a status read that returned that bit as 1. A write of 1 to a flag bit has no effect. A write of 0 with no such prior read also has no effect.
- R5: When a frame completes while receive-full is 1, overrun is set and the receive data register keeps its previous byte.
- R6: While overrun is 1, no frame starts and the serial clock stays high. Once overrun is cleared, a pending transmit byte is sent.
- R7: The transmit interrupt equals transmit-empty AND the transmit interrupt enable. The receive-full interrupt equals receive-full AND the receive interrupt enable AND NOT overrun. The receive-error interrupt equals overrun AND the receive interrupt enable.
- R8: A DMA write strobe loads the transmit register from the write data and clears transmit-empty. A DMA read strobe presents the receive register on the read data bus and clears receive-full.
- R9: Frames are 8 bits, LSB first. The transmit line changes only when the serial clock falls, and the receive line is sampled on the rising edge. With the transmit line looped back to the receive line, every byte sent arrives unchanged in the receive register, with receive-full set.
- R10: When receive is disabled, a completed frame changes neither the receive register nor any receive flag.
- R11: Each serial clock phase lasts HALF_DIV system clocks. If data is pending when a frame ends, the next frame follows with no high phase longer than HALF_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (arms status flags for clearing) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data for host and DMA writes |
| rdata | output | 8 | Read data (receive register while DMA read strobe is high) |
| dma_tx_wr | input | 1 | DMA write of the transmit register |
| dma_rx_rd | input | 1 | DMA read of the receive register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| sck | output | 1 | Serial clock, idles high |
| irq_txe | output | 1 | Transmit-empty interrupt request |
| irq_rxf | output | 1 | Receive-full interrupt request |
| irq_rxerr | output | 1 | Receive-error (overrun) interrupt request |

## Verification
The bench builds the block with HALF_DIV = 2, so a frame takes only 32 system clocks. The transmit line is looped back to the receive line. This short frame makes it affordable to send all 256 byte values through the full load, start, receive and clear sequence. It also leaves room to exercise the timing-sensitive cases: refilling the transmit register during a frame, letting a frame land on an uncollected byte, and proving that a frozen unit keeps its clock high.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [1:0] {
        A_TDR  = 2'd0,
        A_RDR  = 2'd1,
        A_STAT = 2'd2,
        A_CTRL = 2'd3
    } addr_e;

    localparam int F_TXE = 0;
    localparam int F_RXF = 1;
    localparam int F_OVR = 2;
    localparam int NFLAG = 3;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

endpackage

// File: rtl/sst_shifter.sv
module sst_shifter #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tdr_i,
    input  logic       rxd_i,
    output logic       start_o,
    output logic       done_o,
    output logic [7:0] rx_byte_o,
    output logic       sck_o,
    output logic       txd_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic          busy;
        logic          hi;
        logic [2:0]    bitn;
        logic [CW-1:0] div;
        logic [7:0]    tsh;
        logic [7:0]    rsh;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick;

    always_comb begin
        eng_d   = eng_q;
        start_o = 1'b0;
        done_o  = 1'b0;
        tick    = (eng_q.div == DIV_LAST);
        rx_byte_o = {rxd_i, eng_q.rsh[7:1]};
        if (!eng_q.busy) begin
            if (go_i) begin
                start_o    = 1'b1;
                eng_d.busy = 1'b1;
                eng_d.hi   = 1'b0;
                eng_d.bitn = '0;
                eng_d.div  = '0;
                eng_d.tsh  = tdr_i;
            end
        end else if (!tick) begin
            eng_d.div = eng_q.div + 1'b1;
        end else begin
            eng_d.div = '0;
            if (!eng_q.hi) begin
                eng_d.hi  = 1'b1;
                eng_d.rsh = {rxd_i, eng_q.rsh[7:1]};
                done_o    = (eng_q.bitn == 3'd7);
            end else if (eng_q.bitn != 3'd7) begin
                eng_d.hi   = 1'b0;
                eng_d.bitn = eng_q.bitn + 3'd1;
                eng_d.tsh  = {1'b1, eng_q.tsh[7:1]};
            end else if (go_i) begin
                start_o    = 1'b1;
                eng_d.hi   = 1'b0;
                eng_d.bitn = '0;
                eng_d.tsh  = tdr_i;
            end else begin
                eng_d.busy = 1'b0;
                eng_d.tsh  = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.tsh  <= '1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sck_o = !(eng_q.busy && !eng_q.hi);
    assign txd_o = eng_q.tsh[0];

    // R9
    txd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_o != $past(txd_o)) |-> ($fell(sck_o) || (sck_o && !eng_q.busy)));

    // R11
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && !tick) |=> $stable(sck_o));

endmodule

// File: rtl/sst_regs.sv
module sst_regs
    import sst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       dma_tx_wr,
    input  logic       dma_rx_rd,
    input  logic       start_i,
    input  logic       done_i,
    input  logic [7:0] rx_byte_i,
    output logic [7:0] rdata,
    output logic [7:0] tdr_o,
    output logic       go_o,
    output logic       irq_txe_o,
    output logic       irq_rxf_o,
    output logic       irq_rxerr_o
);
    typedef struct packed {
        logic [7:0]       tdr;
        logic [7:0]       rdr;
        logic [NFLAG-1:0] flg;
        logic [NFLAG-1:0] arm;
        ctrl_t            ctrl;
    } regs_t;

    regs_t reg_d, reg_q;
    logic [7:0] status;
    addr_e      a;

    assign status = {5'b0, reg_q.flg};
    assign a      = addr_e'(addr);

    always_comb begin
        reg_d = reg_q;
        if (rd_en && a == A_STAT)
            reg_d.arm = reg_q.arm | reg_q.flg;
        if (wr_en) begin
            case (a)
                A_TDR:  reg_d.tdr = wdata;
                A_STAT: begin
                    for (int i = 0; i < NFLAG; i++) begin
                        if (!wdata[i] && reg_q.arm[i]) begin
                            reg_d.flg[i] = 1'b0;
                            reg_d.arm[i] = 1'b0;
                        end
                    end
                end
                A_CTRL: reg_d.ctrl = ctrl_t'(wdata[3:0]);
                default: ;
            endcase
        end
        if (dma_tx_wr) begin
            reg_d.tdr        = wdata;
            reg_d.flg[F_TXE] = 1'b0;
            reg_d.arm[F_TXE] = 1'b0;
        end
        if (dma_rx_rd) begin
            reg_d.flg[F_RXF] = 1'b0;
            reg_d.arm[F_RXF] = 1'b0;
        end
        if (start_i) begin
            reg_d.flg[F_TXE] = 1'b1;
            reg_d.arm[F_TXE] = 1'b0;
        end
        if (done_i && reg_q.ctrl.rx_en) begin
            if (reg_d.flg[F_RXF]) begin
                reg_d.flg[F_OVR] = 1'b1;
                reg_d.arm[F_OVR] = 1'b0;
            end else begin
                reg_d.rdr        = rx_byte_i;
                reg_d.flg[F_RXF] = 1'b1;
                reg_d.arm[F_RXF] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q            <= '0;
            reg_q.flg[F_TXE] <= 1'b1;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        if (dma_rx_rd) rdata = reg_q.rdr;
        else begin
            case (a)
                A_TDR:   rdata = reg_q.tdr;
                A_RDR:   rdata = reg_q.rdr;
                A_STAT:  rdata = status;
                default: rdata = {4'b0, reg_q.ctrl};
            endcase
        end
    end

    assign tdr_o       = reg_q.tdr;
    assign go_o        = reg_q.ctrl.tx_en && !reg_q.flg[F_TXE] && !reg_q.flg[F_OVR];
    assign irq_txe_o   = reg_q.ctrl.tx_ie && reg_q.flg[F_TXE];
    assign irq_rxf_o   = reg_q.ctrl.rx_ie && reg_q.flg[F_RXF] && !reg_q.flg[F_OVR];
    assign irq_rxerr_o = reg_q.ctrl.rx_ie && reg_q.flg[F_OVR];

    // R3
    txe_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> reg_q.flg[F_TXE]);

    // R6
    ovr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.flg[F_OVR] |-> !start_i);

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && reg_q.ctrl.rx_en && reg_q.flg[F_RXF] && !wr_en && !dma_rx_rd)
        |=> (reg_q.flg[F_OVR] && $stable(reg_q.rdr)));

    // R4
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.flg[F_RXF] && wr_en && a == A_STAT && wdata[F_RXF] && !dma_rx_rd)
        |=> reg_q.flg[F_RXF]);

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       dma_tx_wr,
    input  logic       dma_rx_rd,
    input  logic       rxd,
    output logic       txd,
    output logic       sck,
    output logic       irq_txe,
    output logic       irq_rxf,
    output logic       irq_rxerr
);
    logic       go, start, done;
    logic [7:0] tdr, rx_byte;

    sst_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd),
        .start_i(start), .done_i(done), .rx_byte_i(rx_byte), .rdata(rdata),
        .tdr_o(tdr), .go_o(go), .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf),
        .irq_rxerr_o(irq_rxerr)
    );

    sst_shifter #(.HALF_DIV(HALF_DIV)) i_shifter (
        .clk(clk), .rst_n(rst_n), .go_i(go), .tdr_i(tdr), .rxd_i(rxd),
        .start_o(start), .done_o(done), .rx_byte_o(rx_byte),
        .sck_o(sck), .txd_o(txd)
    );

endmodule

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int HD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, dma_tx_wr = 1'b0, dma_rx_rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic txd, sck, rxd, irq_txe, irq_rxf, irq_rxerr;
    int checks = 0, errors = 0;
    bit mon_on = 1'b0;
    int run = 0, maxrun = 0;

    assign rxd = txd;
    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_xcvr #(.HALF_DIV(HD)) i_sync_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd),
        .rxd(rxd), .txd(txd), .sck(sck), .irq_txe(irq_txe), .irq_rxf(irq_rxf),
        .irq_rxerr(irq_rxerr)
    );

    always @(negedge clk) if (mon_on) begin
        if (sck) run = run + 1; else run = 0;
        if (run > maxrun) maxrun = run;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_stat(input int bitn, input string req);
        logic [7:0] s;
        int n = 0;
        do begin rd(2'd2, s); n++; end while (!s[bitn] && n < 200);
        check(req, int'(s[bitn]), 1);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] s;
        wr(2'd0, b); rd(2'd2, s); wr(2'd2, 8'h06);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, r;
        int lo, hi;
        idle(3); rst_n = 1'b1;
        // R1 reset state
        rd(2'd2, s); check("R1 status", s, 8'h01);
        rd(2'd3, s); check("R1 ctrl", s, 8'h00);
        check("R1 sck", sck, 1); check("R1 txd", txd, 1);
        check("R1 irqs", {irq_txe, irq_rxf, irq_rxerr}, 0);

        // R7 interrupts masked until enabled, then transmit-empty raises
        wr(2'd3, 8'h03); idle(1); check("R7 txe masked", irq_txe, 0);
        wr(2'd3, 8'h0F); idle(1); check("R7 txe irq", irq_txe, 1);

        // R9 R2 exhaustive loopback sweep
        for (int b = 0; b < 256; b++) begin
            send(8'(b));
            wait_stat(1, "R9 rxf");
            check("R7 rxf irq", irq_rxf, 1);
            rd(2'd1, r); check("R9 data", r, b);
            wr(2'd2, 8'h05);
        end
        idle(10);
        rd(2'd2, s); check("R4 rxf cleared", s[1], 0);

        // R11 clock phase widths
        wr(2'd0, 8'hA5); rd(2'd2, s); wr(2'd2, 8'h06);
        lo = 0; hi = 0;
        while (sck) @(negedge clk);
        while (!sck) begin lo++; @(negedge clk); end
        while (sck) begin hi++; @(negedge clk); end
        check("R11 low phase", lo, HD); check("R11 high phase", hi, HD);
        wait_stat(1, "R9 rxf");

        // R4 write of 1 leaves flag set
        wr(2'd2, 8'h07); rd(2'd2, s); check("R4 write one", s[1], 1);
        wr(2'd2, 8'h05); rd(2'd2, s); check("R4 clear", s[1], 0);
        // R4 write 0 without prior read
        send(8'h3C);
        while (!irq_rxf) @(negedge clk);
        wr(2'd2, 8'h05); rd(2'd2, s); check("R4 no read no clear", s[1], 1);
        wr(2'd2, 8'h05); idle(10);

        // R5 overrun
        send(8'h11); wait_stat(1, "R9 rxf");
        send(8'h22); wait_stat(2, "R5 ovr");
        rd(2'd1, r); check("R5 rdr kept", r, 8'h11);
        check("R7 rxerr irq", irq_rxerr, 1); check("R7 rxf masked by ovr", irq_rxf, 0);
        idle(10);

        // R6 frozen while overrun
        wr(2'd0, 8'h33); rd(2'd2, s); wr(2'd2, 8'h06);
        lo = 0;
        repeat (40) begin @(negedge clk); if (!sck) lo++; end
        check("R6 no clock", lo, 0);
        rd(2'd2, s); check("R6 pending", s, 8'h06);
        wr(2'd2, 8'h01);
        wait_stat(1, "R6 resume");
        rd(2'd1, r); check("R6 resumed data", r, 8'h33);
        wr(2'd2, 8'h05); idle(10);

        // R8 DMA transmit and receive
        @(negedge clk); dma_tx_wr = 1'b1; wdata = 8'h5A;
        @(negedge clk); dma_tx_wr = 1'b0;
        wait_stat(1, "R8 rxf");
        @(negedge clk); dma_rx_rd = 1'b1; #1 check("R8 dma data", rdata, 8'h5A);
        @(negedge clk); dma_rx_rd = 1'b0;
        rd(2'd2, s); check("R8 rxf cleared", s[1], 0);
        idle(10);

        // R11 R9 back-to-back frames
        send(8'hC3);
        while (sck) @(negedge clk);
        run = 0; maxrun = 0; mon_on = 1'b1;
        send(8'h96);
        wait_stat(1, "R9 first rxf");
        @(negedge clk); dma_rx_rd = 1'b1; #1 check("R9 first byte", rdata, 8'hC3);
        @(negedge clk); dma_rx_rd = 1'b0;
        wait_stat(1, "R9 second rxf");
        mon_on = 1'b0;
        check("R11 no gap", maxrun <= HD, 1);
        rd(2'd1, r); check("R9 second byte", r, 8'h96);
        rd(2'd2, s); check("R5 no overrun", s[2], 0);
        wr(2'd2, 8'h05); idle(10);

        // R3 transmit disabled
        wr(2'd3, 8'h0E); send(8'h77);
        lo = 0;
        repeat (40) begin @(negedge clk); if (!sck) lo++; end
        check("R3 no start", lo, 0);
        rd(2'd2, s); check("R3 txe held", s[0], 0);
        wr(2'd3, 8'h0F); idle(3);
        rd(2'd2, s); check("R3 txe reload", s[0], 1);
        wait_stat(1, "R3 frame");
        wr(2'd2, 8'h05); idle(10);

        // R10 receive disabled
        wr(2'd3, 8'h0D); send(8'hEE); idle(60);
        rd(2'd2, s); check("R10 no rxf", s[1], 0);
        rd(2'd1, r); check("R10 rdr kept", r, 8'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule